// File: doc/BRIEF.md
# Shared Execution Pipeline with Tagged Result Return

This block lets several computation units share a single execution pipeline. Each unit presents operands on its own valid/ready request port. A round-robin arbiter admits at most one operand set per cycle. The winning unit's index is written into the pipeline as a tag and travels with the operands through every stage. When the result reaches the last stage, the tag steers it to that same unit's valid/ready result port.

The operation is a placeholder: a sum or an exclusive-or, picked per request. The pipeline is `STAGES` deep. A request can be marked for early completion. Such a request goes straight into the last stage when every stage ahead of the last one is empty. Because the return path is chosen by the tag and not by a fixed-latency timing chain, completion time can vary without misrouting a result.

Back-pressure rules: the pipeline moves forward only while its last stage is empty or is being taken by the unit it is addressed to. When the addressed unit holds `res_ready` low, every stage holds its contents and no request port sees ready. Each unit's result valid, once raised, stays raised with stable data until that unit's ready is high.

Top module: `fanin_pipe_shared`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, every `res_valid` bit is low and no stage holds a result.
- R2: At most one `req_ready` bit is high in any cycle, and only for a unit whose `req_valid` is high.
- R3: The unit granted is the first one with valid high, searching upward from a rotating pointer and wrapping at `N_UNITS`. The pointer starts at unit 0 and moves to the granted index plus one after each accepted request.
- R4: A request is accepted only in a cycle where the last stage is empty, or where it is being taken by its addressed unit.
- R5: `req_op` = 0 yields `a + b` modulo 2^`DATA_W`; `req_op` = 1 yields `a ^ b`.
- R6: A request accepted with `req_early` = 0 shows as a result `STAGES` clock edges after acceptance when no stall occurs.
- R7: A request accepted with `req_early` = 1, while all stages before the last are empty, shows as a result on the first edge after acceptance. Otherwise it goes through the normal stage path.
- R8: A result is presented only on the port of the unit that issued it, and at most one `res_valid` bit is high at a time.
- R9: While a presented result is not taken, its `res_valid` and `res_data` hold unchanged.
- R10: Each unit receives its results in the order it issued them. Because nothing overtakes, results leave in global acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N_UNITS | Per-unit request valid |
| req_ready | output | N_UNITS | Per-unit request ready (only the winner) |
| req_a | input | N_UNITS*DATA_W | Per-unit first operand, unit u at bits u*DATA_W upward |
| req_b | input | N_UNITS*DATA_W | Per-unit second operand, same packing |
| req_op | input | N_UNITS | Per-unit operation select (0 sum, 1 xor) |
| req_early | input | N_UNITS | Per-unit early-completion request |
| res_valid | output | N_UNITS | Per-unit result valid |
| res_ready | input | N_UNITS | Per-unit result ready |
| res_data | output | N_UNITS*DATA_W | Per-unit result data; zero on ports not addressed |

## Verification
The bench builds the block with three units, an 8-bit data path and four stages. Three units make the tag width two bits with one code unused, so pointer wrap-around at a count that is not a power of two gets exercised. The narrow data width makes sum overflow frequent. Four stages leave room for early requests to be seen both bypassing an empty pipe and falling back to the normal path behind older work, while random result back-pressure holds the whole pipe with several tags in flight.

// File: rtl/fp_pkg.sv
package fp_pkg;
  typedef enum logic {
    FP_OP_SUM = 1'b0,
    FP_OP_XOR = 1'b1
  } fp_op_e;

  function automatic int unsigned tag_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/fp_rr_arbiter.sv
module fp_rr_arbiter #(
  parameter int unsigned N_UNITS = 4,
  localparam int unsigned TAG_W  = fp_pkg::tag_width(N_UNITS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_UNITS-1:0] req,
  input  logic               take,
  output logic [N_UNITS-1:0] gnt,
  output logic [TAG_W-1:0]   gnt_idx,
  output logic               any
);
  localparam logic [TAG_W-1:0] LAST = TAG_W'(N_UNITS - 1);

  logic [TAG_W-1:0] ptr_q;

  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    any     = 1'b0;
    for (int k = 0; k < N_UNITS; k++) begin
      int unsigned idx;
      idx = (int'(ptr_q) + k) % N_UNITS;
      if (!any && req[idx]) begin
        any      = 1'b1;
        gnt_idx  = TAG_W'(idx);
        gnt[idx] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (any && take) begin
      ptr_q <= (gnt_idx == LAST) ? '0 : gnt_idx + 1'b1;
    end
  end
endmodule

// File: rtl/fp_stage_chain.sv
module fp_stage_chain #(
  parameter int unsigned STAGES = 4,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned TAG_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  input  logic              in_valid,
  input  logic              in_early,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [TAG_W-1:0]  out_tag,
  output logic [DATA_W-1:0] out_data
);
  localparam int unsigned LAST = STAGES - 1;

  logic              vld_q [STAGES];
  logic [TAG_W-1:0]  tag_q [STAGES];
  logic [DATA_W-1:0] dat_q [STAGES];
  logic              ahead_empty;
  logic              jump;

  generate
    if (STAGES > 1) begin : g_multi
      always_comb begin
        ahead_empty = 1'b1;
        for (int i = 0; i < LAST; i++) begin
          if (vld_q[i]) ahead_empty = 1'b0;
        end
      end
    end else begin : g_single
      assign ahead_empty = 1'b1;
    end
  endgenerate

  assign jump = in_valid && in_early && ahead_empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) begin
        vld_q[i] <= 1'b0;
        tag_q[i] <= '0;
        dat_q[i] <= '0;
      end
    end else if (advance) begin
      for (int i = LAST; i > 0; i--) begin
        vld_q[i] <= vld_q[i-1];
        tag_q[i] <= tag_q[i-1];
        dat_q[i] <= dat_q[i-1];
      end
      vld_q[0] <= in_valid && !jump;
      tag_q[0] <= in_tag;
      dat_q[0] <= in_data;
      if (jump) begin
        vld_q[LAST] <= 1'b1;
        tag_q[LAST] <= in_tag;
        dat_q[LAST] <= in_data;
      end
    end
  end

  assign out_valid = vld_q[LAST];
  assign out_tag   = tag_q[LAST];
  assign out_data  = dat_q[LAST];
endmodule

// File: rtl/fp_result_router.sv
module fp_result_router #(
  parameter int unsigned N_UNITS = 4,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned TAG_W   = 2
) (
  input  logic                      out_valid,
  input  logic [TAG_W-1:0]          out_tag,
  input  logic [DATA_W-1:0]         out_data,
  input  logic [N_UNITS-1:0]        res_ready,
  output logic [N_UNITS-1:0]        res_valid,
  output logic [N_UNITS*DATA_W-1:0] res_data,
  output logic                      taken
);
  logic [N_UNITS-1:0] hit;

  for (genvar u = 0; u < N_UNITS; u++) begin : g_port
    assign hit[u] = out_valid && (out_tag == TAG_W'(u));
    assign res_valid[u] = hit[u];
    assign res_data[u*DATA_W +: DATA_W] = hit[u] ? out_data : '0;
  end

  assign taken = |(hit & res_ready);
endmodule

// File: rtl/fanin_pipe_shared.sv
module fanin_pipe_shared #(
  parameter int unsigned N_UNITS = 4,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned STAGES  = 4,
  localparam int unsigned TAG_W  = fp_pkg::tag_width(N_UNITS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_UNITS-1:0]        req_valid,
  output logic [N_UNITS-1:0]        req_ready,
  input  logic [N_UNITS*DATA_W-1:0] req_a,
  input  logic [N_UNITS*DATA_W-1:0] req_b,
  input  logic [N_UNITS-1:0]        req_op,
  input  logic [N_UNITS-1:0]        req_early,
  output logic [N_UNITS-1:0]        res_valid,
  input  logic [N_UNITS-1:0]        res_ready,
  output logic [N_UNITS*DATA_W-1:0] res_data
);
  import fp_pkg::*;

  logic [N_UNITS-1:0] gnt;
  logic [TAG_W-1:0]   gnt_idx;
  logic               gnt_any;
  logic               advance;
  logic               taken;
  logic               tail_valid;
  logic [TAG_W-1:0]   tail_tag;
  logic [DATA_W-1:0]  tail_data;
  logic [DATA_W-1:0]  opa, opb, result;
  fp_op_e             op_sel;
  logic               early_sel;

  assign advance = !tail_valid || taken;

  fp_rr_arbiter #(.N_UNITS(N_UNITS)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req_valid),
    .take    (advance),
    .gnt     (gnt),
    .gnt_idx (gnt_idx),
    .any     (gnt_any)
  );

  assign req_ready = advance ? gnt : '0;

  always_comb begin
    opa       = req_a[gnt_idx*DATA_W +: DATA_W];
    opb       = req_b[gnt_idx*DATA_W +: DATA_W];
    op_sel    = fp_op_e'(req_op[gnt_idx]);
    early_sel = req_early[gnt_idx];
    case (op_sel)
      FP_OP_XOR: result = opa ^ opb;
      default:   result = opa + opb;
    endcase
  end

  fp_stage_chain #(.STAGES(STAGES), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_chain (
    .clk       (clk),
    .rst_n     (rst_n),
    .advance   (advance),
    .in_valid  (gnt_any),
    .in_early  (early_sel),
    .in_tag    (gnt_idx),
    .in_data   (result),
    .out_valid (tail_valid),
    .out_tag   (tail_tag),
    .out_data  (tail_data)
  );

  fp_result_router #(.N_UNITS(N_UNITS), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_route (
    .out_valid (tail_valid),
    .out_tag   (tail_tag),
    .out_data  (tail_data),
    .res_ready (res_ready),
    .res_valid (res_valid),
    .res_data  (res_data),
    .taken     (taken)
  );
endmodule

// File: rtl/fp_chk.sv
module fp_chk #(
  parameter int unsigned N_UNITS = 4,
  parameter int unsigned DATA_W  = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [N_UNITS-1:0]        req_valid,
  input logic [N_UNITS-1:0]        req_ready,
  input logic [N_UNITS-1:0]        res_valid,
  input logic [N_UNITS-1:0]        res_ready,
  input logic [N_UNITS*DATA_W-1:0] res_data
);
  // R2
  one_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready));
  // R2
  ready_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready & ~req_valid) == '0);
  // R8
  one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(res_valid));
  // R4
  no_accept_when_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(res_valid & ~res_ready)) |-> (req_ready == '0));
  // R9
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(res_valid & ~res_ready)) |=> $stable(res_valid));
  // R9
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(res_valid & ~res_ready)) |=> $stable(res_data));
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (res_valid == '0));
endmodule

bind fanin_pipe_shared fp_chk #(.N_UNITS(N_UNITS), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_data  (res_data)
);

// File: tb/tb_fanin_pipe_shared.sv
module tb_fanin_pipe_shared;
  localparam int NU = 3;
  localparam int W  = 8;
  localparam int S  = 4;

  typedef struct {
    int         tag;
    logic [W-1:0] data;
    int         pos;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NU-1:0]   req_valid = '0, req_op = '0, req_early = '0, res_ready = '0;
  logic [NU*W-1:0] req_a = '0, req_b = '0;
  logic [NU-1:0]   req_ready, res_valid;
  logic [NU*W-1:0] res_data;

  always #10 clk = ~clk;

  fanin_pipe_shared #(.N_UNITS(NU), .DATA_W(W), .STAGES(S)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_a(req_a), .req_b(req_b), .req_op(req_op), .req_early(req_early),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  item_t mq[$];
  logic [W-1:0] exp_q[NU][$];
  int ptr = 0;
  logic [NU-1:0] seen_valid;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] calc(input logic [W-1:0] a, b, input logic op);
    return op ? (a ^ b) : W'(a + b);
  endfunction

  task automatic step(input logic [NU-1:0] v, e, o, r, input logic [NU*W-1:0] a, b);
    bit out, consumed, adv, found, ahead_empty;
    int w, tg;
    logic [NU-1:0] exp_rv, exp_rdy;
    @(negedge clk);
    req_valid = v; req_early = e; req_op = o; res_ready = r; req_a = a; req_b = b;
    #2;
    out = (mq.size() > 0) && (mq[0].pos == S-1);
    tg = out ? mq[0].tag : 0;
    consumed = out && r[tg];
    adv = !out || consumed;
    found = 0; w = 0;
    for (int k = 0; k < NU; k++) begin
      int idx = (ptr + k) % NU;
      if (!found && v[idx]) begin found = 1; w = idx; end
    end
    exp_rv = out ? NU'(1) << tg : '0;
    exp_rdy = (adv && found) ? NU'(1) << w : '0;
    seen_valid = res_valid;
    check(req_ready == exp_rdy, "R2/R3/R4 req_ready", req_ready, exp_rdy);
    check(res_valid == exp_rv, "R6/R7/R8/R9 res_valid", res_valid, exp_rv);
    if (out)
      check(res_data[tg*W +: W] == mq[0].data, "R5/R9 res_data", res_data[tg*W +: W], mq[0].data);
    if (consumed) begin
      logic [W-1:0] want;
      want = (exp_q[tg].size() > 0) ? exp_q[tg].pop_front() : 'x;
      check(res_data[tg*W +: W] === want, "R10 per-unit order", res_data[tg*W +: W], want);
    end
    if (adv) begin
      if (consumed) void'(mq.pop_front());
      ahead_empty = 1;
      foreach (mq[i]) if (mq[i].pos < S-1) ahead_empty = 0;
      foreach (mq[i]) mq[i].pos++;
      if (found) begin
        item_t it;
        it.tag = w;
        it.data = calc(a[w*W +: W], b[w*W +: W], o[w]);
        it.pos = (e[w] && ahead_empty) ? S-1 : 0;
        mq.push_back(it);
        exp_q[w].push_back(it.data);
        ptr = (w + 1) % NU;
      end
    end
  endtask

  function automatic logic [NU-1:0] rbits(input int pct);
    logic [NU-1:0] x;
    for (int i = 0; i < NU; i++) x[i] = ($urandom_range(99) < pct);
    return x;
  endfunction

  function automatic logic [NU*W-1:0] rdata();
    logic [NU*W-1:0] x;
    for (int i = 0; i < NU; i++) x[i*W +: W] = W'($urandom);
    return x;
  endfunction

  initial begin
    int k;
    repeat (3) @(posedge clk);
    #2;
    // R1: outputs quiet during reset
    check(res_valid == '0, "R1 reset res_valid", res_valid, 0);
    @(negedge clk); rst_n = 1'b1;
    #2;
    check(res_valid == '0, "R1 after reset res_valid", res_valid, 0);
    // R5 R3 random phases: dense, sparse, heavy back-pressure, early-heavy
    for (int ph = 0; ph < 4; ph++) begin
      int pv = (ph == 1) ? 20 : 80;
      int pr = (ph == 2) ? 25 : 85;
      int pe = (ph == 3) ? 70 : 10;
      for (int c = 0; c < 400; c++)
        step(rbits(pv), rbits(pe), rbits(50), rbits(pr), rdata(), rdata());
    end
    // drain
    repeat (S + 6) step('0, '0, '0, '1, '0, '0);
    // R6: normal latency from unit 1
    step(3'b010, '0, '0, '1, {W'(0), W'(8'h21), W'(0)}, {W'(0), W'(8'h03), W'(0)});
    k = 0;
    do begin step('0, '0, '0, '1, '0, '0); k++; end while (!seen_valid[1] && k < 20);
    check(k == S, "R6 normal latency", k, S);
    repeat (S + 2) step('0, '0, '0, '1, '0, '0);
    // R7: early completion on an empty pipe
    step(3'b100, 3'b100, 3'b100, '1, {W'(8'hF0), W'(0), W'(0)}, {W'(8'h0F), W'(0), W'(0)});
    k = 0;
    do begin step('0, '0, '0, '1, '0, '0); k++; end while (!seen_valid[2] && k < 20);
    check(k == 1, "R7 early latency", k, 1);
    repeat (S + 2) step('0, '0, '0, '1, '0, '0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule